// File: doc/BRIEF.md
# Step Pulse Generator with Direction Timing Guards

This block turns a signed step-rate word into motor step pulses. A 32-bit phase accumulator adds the magnitude of the rate on every enabled clock, and each carry out asks for one step. A sequencer issues the steps while it enforces four programmable windows, all counted in clock cycles: the minimum pulse length, the minimum idle gap between pulses, the time the direction must be stable before a pulse, and the time it must stay stable after one. Requests that arrive while any window is still running are queued and issued later, so none is lost.

Three output formats share one pair of pins. In step/direction format one pin pulses and the other gives the sign. In up/down format each sign has its own pulse pin. In quadrature format every step walks once around a two-bit Gray cycle. A signed counter reports how many steps have been issued. An enable input stops new steps, and a host writes the rate through a single write strobe.

Top module: `step_pulse_gen`

## Requirements
- R1: With `fmt` = 0 (and also 3), `out_a` is the step pulse, high while a step is active, and `out_b` is the direction, where 1 means negative.
- R2: With `fmt` = 1, a positive step pulses `out_a` only and a negative step pulses `out_b` only. The two pins are never high together.
- R3: With `fmt` = 2, the code {`out_a`,`out_b`} runs 00,01,11,10,00 once for each positive step and 00,10,11,01,00 once for each negative step. Exactly one bit changes at each transition.
- R4: Each step pulse in formats 0 and 1, and each non-zero Gray state in format 2, lasts exactly max(`step_len`,1) cycles.
- R5: Between the end of one step and the start of the next, the outputs stay idle for at least `step_space` cycles.
- R6: After the direction changes, at least max(`dir_setup`,1) cycles pass before the next step starts.
- R7: The direction never changes during a step, and it changes only after the outputs have been idle for at least `dir_hold` cycles since the last step.
- R8: While `enable` is low, no new step starts, `fb_count` holds its value and the queue of waiting requests is emptied. A step that is already in progress runs to completion.
- R9: `fb_count` moves by exactly +1 or -1, matching the direction, in the cycle in which each step starts, and at no other time.
- R10: Starting from reset with a constant rate R applied for M accumulator updates, followed by a drain period, exactly floor(M·|R|/2^32) steps are issued, even when the timing windows make the request rate higher than the step rate.
- R11: A write of a non-zero rate sets the commanded direction from its sign, and if that sign differs from the previous command it discards any queued requests. A write of zero stops requests and keeps the current direction.
- R12: After reset, `out_a` = 0, `out_b` = 0 and `fb_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows steps to be generated |
| rate_we | input | 1 | Write strobe for the rate register |
| rate_wdata | input | RW (32) | Signed step-rate word, in steps per clock scaled by 2^32 |
| fmt | input | 2 | Output format: 0 step/dir, 1 up/down, 2 quadrature, 3 same as 0 |
| step_len | input | TW (16) | Pulse length in cycles (0 is treated as 1) |
| step_space | input | TW (16) | Minimum idle gap between steps in cycles |
| dir_setup | input | TW (16) | Direction setup time in cycles |
| dir_hold | input | TW (16) | Direction hold time in cycles |
| out_a | output | 1 | Step, up, or quadrature bit A |
| out_b | output | 1 | Direction, down, or quadrature bit B |
| fb_count | output | CW (32) | Signed count of the steps issued |

## Verification
On every cycle the assertions check that the feedback count moves only by one and only at the start of a step, that no step starts without enable, and that direction stays frozen while a pulse is active. They also check that the up and down pins are never high together, that a Gray code moves one bit at a time, and that each pulse ends after exactly the programmed length. Other properties depend on history over many cycles, and only the bench scenarios can show them: the exact number of steps produced by a rate over a long window, that queued requests survive the timing guards, the setup and hold gaps around a reversal of direction, and that a zero rate keeps the last direction.

// File: rtl/spg_pkg.sv
// Shared types for the step pulse generator.
// Assumes: output format code is two bits wide; code 3 falls back to step/dir.
package spg_pkg;

    typedef enum logic [1:0] {
        FMT_STEPDIR = 2'd0,
        FMT_UPDOWN  = 2'd1,
        FMT_QUAD    = 2'd2,
        FMT_SPARE   = 2'd3
    } fmt_e;

    // Position index 0..3 to two-bit Gray code {a,b}: 00, 01, 11, 10.
    function automatic logic [1:0] gray_of(input logic [1:0] idx);
        return {idx[1], idx[1] ^ idx[0]};
    endfunction

endpackage

// File: rtl/spg_rate_nco.sv
// Rate register and phase accumulator.
// Holds the host's signed rate word, adds its magnitude to an accumulator on each
// enabled cycle and raises req on carry out. Tracks the commanded sign (zero keeps
// the last sign) and pulses flush when a non-zero write reverses it.
// Assumes: rate_wdata is two's complement; the most negative word means 2^(RW-1).
module spg_rate_nco #(
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          rate_we,
    input  logic [RW-1:0] rate_wdata,
    output logic          req,
    output logic          flush,
    output logic          want_dir
);

    logic [RW-1:0] rate_q;
    logic [RW-1:0] acc;
    logic [RW-1:0] mag;
    logic [RW:0]   sum;

    // Magnitude, accumulator sum, carry request and reversal detect.
    always_comb begin
        mag   = rate_q[RW-1] ? ((~rate_q) + RW'(1)) : rate_q;
        sum   = {1'b0, acc} + {1'b0, mag};
        req   = enable && sum[RW];
        flush = rate_we && (rate_wdata != '0) && (rate_wdata[RW-1] != want_dir);
    end

    // Host write of the rate word and the commanded direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            want_dir <= 1'b0;
        end else if (rate_we) begin
            rate_q <= rate_wdata;
            if (rate_wdata != '0) want_dir <= rate_wdata[RW-1];
        end
    end

    // Phase accumulator advances only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (enable) acc <= sum[RW-1:0];
    end

endmodule

// File: rtl/spg_sequencer.sv
// Step sequencer with timing guards.
// Queues step requests, starts a step only when the length, space, setup and
// hold windows allow, reverses the direction between steps and keeps the
// signed feedback count. A step in quadrature format has three timed phases.
// Assumes: timing inputs are static while steps are in flight.
module spg_sequencer
    import spg_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 16,
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 req,
    input  logic                 flush,
    input  logic                 want_dir,
    input  fmt_e                 fmt,
    input  logic [TW-1:0]        step_len,
    input  logic [TW-1:0]        step_space,
    input  logic [TW-1:0]        dir_setup,
    input  logic [TW-1:0]        dir_hold,
    output logic                 busy,
    output logic [1:0]           phase,
    output logic                 dir,
    output logic signed [CW-1:0] fb_count
);

    localparam logic [TW-1:0] T_MAX = '1;
    localparam logic [PW-1:0] P_MAX = '1;

    logic [TW-1:0] len_cnt;
    logic [TW-1:0] since_end;
    logic [TW-1:0] since_dir;
    logic [TW-1:0] eff_len;
    logic [PW-1:0] pending;
    logic          phase_done;
    logic          last_phase;
    logic          can_start;
    logic          can_turn;

    // Guard evaluation for step start, phase end and direction reversal.
    always_comb begin
        eff_len    = (step_len == '0) ? TW'(1) : step_len;
        phase_done = busy && (len_cnt >= eff_len);
        last_phase = (fmt != FMT_QUAD) || (phase == 2'd3);
        can_start  = !busy && enable && (pending != '0) && (dir == want_dir)
                     && (since_end >= step_space) && (since_dir >= dir_setup);
        can_turn   = !busy && (dir != want_dir) && (since_end >= dir_hold);
    end

    // Queue of requests waiting for the guards, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                pending <= '0;
        else if (flush || !enable) pending <= '0;
        else if (req && !can_start) begin
            if (pending != P_MAX) pending <= pending + PW'(1);
        end else if (!req && can_start) pending <= pending - PW'(1);
    end

    // Pulse timing: phase length and idle time since the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            phase     <= 2'd0;
            len_cnt   <= '0;
            since_end <= T_MAX;
        end else if (can_start) begin
            busy    <= 1'b1;
            phase   <= 2'd1;
            len_cnt <= TW'(1);
        end else if (phase_done) begin
            len_cnt <= TW'(1);
            if (last_phase) begin
                busy      <= 1'b0;
                phase     <= 2'd0;
                since_end <= TW'(1);
            end else begin
                phase <= phase + 2'd1;
            end
        end else if (busy) begin
            len_cnt <= len_cnt + TW'(1);
        end else if (since_end != T_MAX) begin
            since_end <= since_end + TW'(1);
        end
    end

    // Direction register and time since it last changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir       <= 1'b0;
            since_dir <= T_MAX;
        end else if (can_turn) begin
            dir       <= ~dir;
            since_dir <= TW'(1);
        end else if (since_dir != T_MAX) begin
            since_dir <= since_dir + TW'(1);
        end
    end

    // Signed feedback count, one per step start.
    always_ff @(posedge clk) begin
        if (!rst_n)         fb_count <= '0;
        else if (can_start) fb_count <= dir ? (fb_count - CW'(1)) : (fb_count + CW'(1));
    end

endmodule

// File: rtl/spg_formatter.sv
// Output formatter: maps the sequencer state onto the two output pins.
// Assumes: phase runs 1..3 during a quadrature step and is ignored otherwise.
module spg_formatter
    import spg_pkg::*;
(
    input  fmt_e       fmt,
    input  logic       busy,
    input  logic       dir,
    input  logic [1:0] phase,
    output logic       out_a,
    output logic       out_b
);

    logic [1:0] idx;

    // Select pin meaning by format; reverse steps walk the Gray cycle backwards.
    always_comb begin
        idx = dir ? (2'd0 - phase) : phase;
        unique case (fmt)
            FMT_UPDOWN: begin
                out_a = busy && !dir;
                out_b = busy && dir;
            end
            FMT_QUAD: begin
                {out_a, out_b} = busy ? gray_of(idx) : 2'b00;
            end
            default: begin
                out_a = busy;
                out_b = dir;
            end
        endcase
    end

endmodule

// File: rtl/step_pulse_gen.sv
// Step pulse generator top: rate accumulator, guarded sequencer, formatter.
// Assumes: timing and format inputs change only while idle or in reset.
module step_pulse_gen
    import spg_pkg::*;
#(
    parameter int RW = 32,
    parameter int TW = 16,
    parameter int PW = 16,
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 rate_we,
    input  logic [RW-1:0]        rate_wdata,
    input  logic [1:0]           fmt,
    input  logic [TW-1:0]        step_len,
    input  logic [TW-1:0]        step_space,
    input  logic [TW-1:0]        dir_setup,
    input  logic [TW-1:0]        dir_hold,
    output logic                 out_a,
    output logic                 out_b,
    output logic signed [CW-1:0] fb_count
);

    logic       req;
    logic       flush;
    logic       want_dir;
    logic       seq_busy;
    logic       seq_dir;
    logic [1:0] seq_phase;
    fmt_e       fmt_sel;

    assign fmt_sel = fmt_e'(fmt);

    spg_rate_nco #(.RW(RW)) u_nco (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .req        (req),
        .flush      (flush),
        .want_dir   (want_dir)
    );

    spg_sequencer #(.TW(TW), .PW(PW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .req        (req),
        .flush      (flush),
        .want_dir   (want_dir),
        .fmt        (fmt_sel),
        .step_len   (step_len),
        .step_space (step_space),
        .dir_setup  (dir_setup),
        .dir_hold   (dir_hold),
        .busy       (seq_busy),
        .phase      (seq_phase),
        .dir        (seq_dir),
        .fb_count   (fb_count)
    );

    spg_formatter u_fmt (
        .fmt   (fmt_sel),
        .busy  (seq_busy),
        .dir   (seq_dir),
        .phase (seq_phase),
        .out_a (out_a),
        .out_b (out_b)
    );

endmodule

// File: rtl/spg_checker.sv
// Property checker for step_pulse_gen, attached by bind.
// Assumes: step_len and fmt are held constant outside reset.
module spg_checker #(
    parameter int TW = 16,
    parameter int CW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic [1:0]           fmt,
    input logic [TW-1:0]        step_len,
    input logic                 out_a,
    input logic                 out_b,
    input logic signed [CW-1:0] fb_count,
    input logic                 busy,
    input logic                 dir
);

    logic [TW+1:0] hi_run;
    logic [TW+1:0] len_ref;

    // Length of the current run of active-step cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_run <= '0;
        else if (busy) hi_run <= hi_run + (TW+2)'(1);
        else           hi_run <= '0;
    end

    assign len_ref = (step_len == '0) ? (TW+2)'(1) : (TW+2)'(step_len);

    AST_FB_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_count == $past(fb_count)) || (fb_count == $past(fb_count) + CW'(1))
        || (fb_count == $past(fb_count) - CW'(1))); // R9

    AST_FB_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_count != $past(fb_count)) |-> (busy && !$past(busy))); // R9

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(enable)); // R8

    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir)); // R7

    AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd1) |-> !(out_a && out_b)); // R2

    AST_QUAD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd2 && $past(fmt) == 2'd2)
        |-> ($countones({out_a, out_b} ^ {$past(out_a), $past(out_b)}) <= 1)); // R3

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy) && fmt != 2'd2) |-> (hi_run == len_ref)); // R4

endmodule

bind step_pulse_gen spg_checker #(.TW(TW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .fmt      (fmt),
    .step_len (step_len),
    .out_a    (out_a),
    .out_b    (out_b),
    .fb_count (fb_count),
    .busy     (seq_busy),
    .dir      (seq_dir)
);

// File: tb/step_pulse_gen_tb.sv
// Self-checking bench: sweeps formats x rate sign x timing set, plus reversal,
// enable and reset scenarios. A pin monitor checks timing windows independently.
module step_pulse_gen_tb;

    localparam int RW = 32;
    localparam int TW = 16;
    localparam int CW = 32;
    localparam int RUN_K = 1500;
    localparam int DRAIN = 5000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 enable = 1'b0;
    logic                 rate_we = 1'b0;
    logic [RW-1:0]        rate_wdata = '0;
    logic [1:0]           fmt = 2'd0;
    logic [TW-1:0]        step_len = '0;
    logic [TW-1:0]        step_space = '0;
    logic [TW-1:0]        dir_setup = '0;
    logic [TW-1:0]        dir_hold = '0;
    logic                 out_a;
    logic                 out_b;
    logic signed [CW-1:0] fb_count;

    int n_chk = 0;
    int n_bad = 0;
    int mon_chk = 0;
    int mon_bad = 0;

    always #10 clk = ~clk;

    step_pulse_gen #(.RW(RW), .TW(TW), .CW(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .fmt        (fmt),
        .step_len   (step_len),
        .step_space (step_space),
        .dir_setup  (dir_setup),
        .dir_hold   (dir_hold),
        .out_a      (out_a),
        .out_b      (out_b),
        .fb_count   (fb_count)
    );

    // ---------------- pin monitor ----------------
    int       run;
    int       since_d;
    int       pos;
    int       net;
    int       eff;
    int       gd;
    bit       had_pulse;
    bit       had_dchg;
    logic     pa;
    logic     pb;
    logic     s;
    logic [1:0] pcode;
    logic [1:0] code;

    function automatic int gidx(input logic [1:0] c);
        case (c)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    task automatic mchk(input bit ok, input string r, input int act, input int exp);
        mon_chk++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    always @(negedge clk) begin
        eff = (step_len == '0) ? 1 : int'(step_len);
        if (!rst_n) begin
            run = 1; since_d = 0; pos = 0; net = 0;
            had_pulse = 0; had_dchg = 0; pa = 0; pb = 0; pcode = 2'b00;
        end else if (fmt == 2'd2) begin
            code = {out_a, out_b};
            if (code != pcode) begin
                if (pcode != 2'b00) mchk(run == eff, "R4 quad state length", run, eff);
                gd = (gidx(code) - gidx(pcode)) & 3;
                if (gd == 1)      pos++;
                else if (gd == 3) pos--;
                else              mchk(1'b0, "R3 gray jump", gd, 1);
                run = 1;
            end else run++;
            pcode = code;
        end else begin
            s = (fmt == 2'd1) ? (out_a | out_b) : out_a;
            if (fmt != 2'd1 && out_b != pb) begin
                mchk(!s && (!had_pulse || run >= int'(dir_hold)), "R7 dir hold", run, int'(dir_hold));
                had_dchg = 1;
                since_d = 0;
            end
            if (s != pa) begin
                if (s) begin
                    if (had_pulse) mchk(run >= int'(step_space), "R5 step space", run, int'(step_space));
                    if (fmt != 2'd1 && had_dchg)
                        mchk(since_d >= int'(dir_setup) && since_d >= 1, "R6 dir setup", since_d, int'(dir_setup));
                    net += out_b ? -1 : 1;
                    had_pulse = 1;
                end else begin
                    mchk(run == eff, "R4 pulse length", run, eff);
                end
                run = 1;
            end else run++;
            since_d++;
            pa = s;
            pb = out_b;
        end
    end

    function automatic int mon_steps();
        return (fmt == 2'd2) ? (pos / 4) : net;
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic check(input bit ok, input string r, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input int len, input int sp,
                            input int su, input int ho, input bit en);
        @(negedge clk);
        rst_n = 1'b0; rate_we = 1'b0; fmt = f; enable = en;
        step_len = TW'(len); step_space = TW'(sp); dir_setup = TW'(su); dir_hold = TW'(ho);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [RW-1:0] v);
        rate_we = 1'b1; rate_wdata = v;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    // One sweep point: constant rate for RUN_K cycles, then zero rate and drain.
    task automatic sweep_run(input logic [1:0] f, input int cfg, input bit neg);
        logic [RW-1:0] r;
        longint        prod;
        longint        exp_s;
        string         tag;
        r = (cfg == 0) ? 32'h3333_3333 : 32'h0700_0000;
        if (cfg == 0) do_reset(f, 3, 4, 2, 5, 1'b1);
        else          do_reset(f, 0, 1, 3, 2, 1'b1);
        wr(neg ? (~r + 32'd1) : r);
        repeat (RUN_K) @(negedge clk);
        wr('0);
        repeat (DRAIN) @(negedge clk);
        prod  = longint'(RUN_K + 1) * longint'(r);
        exp_s = prod >>> 32;
        if (neg) exp_s = -exp_s;
        tag = (f == 2'd0) ? "R1 step/dir count" : (f == 2'd1) ? "R2 up/down count" : "R3 quad count";
        check(longint'(mon_steps()) == exp_s, tag, mon_steps(), exp_s);
        check(longint'(fb_count) == exp_s, "R10 issued steps", fb_count, exp_s);
        check(fb_count == mon_steps(), "R9 feedback vs pins", fb_count, mon_steps());
        if (f == 2'd2) check((pos % 4) == 0, "R3 full gray cycles", pos % 4, 0);
        if (f == 2'd0) check(out_b == neg, "R1 dir pin", out_b, neg);
    endtask

    // ---------------- main sequence ----------------
    int fb_hold;

    initial begin
        // R12: reset state
        do_reset(2'd0, 3, 4, 2, 5, 1'b1);
        check(out_a == 1'b0, "R12 out_a", out_a, 0);
        check(out_b == 1'b0, "R12 out_b", out_b, 0);
        check(fb_count == 0, "R12 fb_count", fb_count, 0);

        // Sweep: format x timing set x sign (R1..R5, R9, R10)
        for (int f = 0; f < 3; f++)
            for (int cfg = 0; cfg < 2; cfg++)
                for (int ng = 0; ng < 2; ng++)
                    sweep_run(2'(f), cfg, ng[0]);

        // R11: reversal while stepping, then zero keeps direction
        do_reset(2'd0, 3, 4, 2, 5, 1'b1);
        wr(32'h3333_3333);
        repeat (600) @(negedge clk);
        wr(~32'h3333_3333 + 32'd1);
        repeat (600) @(negedge clk);
        wr('0);
        repeat (DRAIN) @(negedge clk);
        check(fb_count == net, "R11 reversal feedback", fb_count, net);
        check(out_b == 1'b1, "R11 zero rate keeps direction", out_b, 1);
        check(had_dchg == 1'b1, "R7 reversal observed", had_dchg, 1);

        // R8: enable low blocks steps
        do_reset(2'd0, 3, 4, 2, 5, 1'b0);
        wr(32'h3333_3333);
        repeat (300) @(negedge clk);
        check(fb_count == 0, "R8 disabled feedback", fb_count, 0);
        check(net == 0, "R8 disabled pins", net, 0);
        enable = 1'b1;
        repeat (300) @(negedge clk);
        check(fb_count > 0, "R8 steps once enabled", fb_count, 1);
        enable = 1'b0;
        repeat (20) @(negedge clk);
        fb_hold = fb_count;
        repeat (300) @(negedge clk);
        check(fb_count == fb_hold, "R8 feedback frozen", fb_count, fb_hold);
        check(out_a == 1'b0, "R8 step pin idle", out_a, 0);
        check(net == fb_count, "R9 pins match feedback", net, fb_count);

        $display("test done: total=%0d bad=%0d", n_chk + mon_chk, n_bad + mon_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk + mon_chk + 1, n_bad + mon_bad + 1);
        $finish;
    end

endmodule